// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block holds the interrupt state for an 18-channel DMA controller and drives a single interrupt line. The transfer engine sends it one-cycle event pulses per channel: an error pulse and a completion pulse. Each pulse sets a sticky flag for its channel. Software reads the flags over a simple 32-bit register bus and clears them by writing ones.

A per-channel enable mask decides which completion flags reach the interrupt line. The mask is read back at one offset. It is changed through two write-one-only offsets: one sets enable bits and the other clears them. Error flags always reach the interrupt line, whatever the enable state. The combined line is registered.

Register reads are combinational. `rdata_o` is valid in the same cycle that `rd_en_i` is high, and it is zero when `rd_en_i` is low. Only the low bits of `addr_i` are decoded. Byte offsets are 0x40, 0x48, 0x50 and 0x58.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, all error flags, completion flags and enables are 0, and `irq_o` is 0.
- R2: An error pulse on `err_evt_i[n]` sets error flag n. The error flags read at offset 0x40 in bits 17:0, with bit n for channel n.
- R3: Writing offset 0x40 clears every error flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged.
- R4: When an error pulse and a clearing write hit the same bit in the same cycle, the flag is 1 afterwards.
- R5: Writing offset 0x48 sets each enable whose write-data bit is 1, and a 0 bit leaves that enable unchanged. Reading 0x48 returns the enable mask in bits 17:0.
- R6: Writing offset 0x50 clears each enable whose write-data bit is 1, and a 0 bit has no effect. Reading 0x50 returns 0.
- R7: A pulse on `done_evt_i[n]` sets completion flag n. The completion flags read at offset 0x58 in bits 17:0. Writing ones there clears flags, and an arriving pulse wins over a clear of the same bit.
- R8: `irq_o` equals, one clock later, the OR of all error flags ORed with the OR of (completion flag AND enable) over all channels. An error flag raises the line even when its channel's enable is 0.
- R9: Bits 31:18 of every read are 0, and writes to those bits change nothing. Reads of offsets not listed above return 0.
- R10: Reads change no state. Two back-to-back reads of the same offset return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid while rd_en_i is high |
| err_evt_i | input | 18 | Per-channel error event pulses |
| done_evt_i | input | 18 | Per-channel completion event pulses |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The register paths are tried with masks that mix set and clear bits. Each mask is followed by a write of all zeros, which separates a true write-one-only port from a plain load. Writes carry ones in the reserved upper bits, which exposes decode that reaches past bit 17. The interrupt line is tried in four cases: an error on a disabled channel, a completion on a disabled channel, the enable arriving afterwards, and the flag being cleared. Together these separate "errors ignore the mask" from "completions need it" and check the one-cycle register stage. Same-cycle pulse-and-clear collisions on both flag banks check the priority rule.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
  localparam int unsigned NCH = 18;
  localparam int unsigned DW  = 32;
  localparam int unsigned AW  = 8;

  localparam logic [AW-1:0] OFS_ERR    = 8'h40;
  localparam logic [AW-1:0] OFS_EN_SET = 8'h48;
  localparam logic [AW-1:0] OFS_EN_CLR = 8'h50;
  localparam logic [AW-1:0] OFS_DONE   = 8'h58;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ERR, SEL_EN_SET, SEL_EN_CLR, SEL_DONE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    case (a)
      OFS_ERR:    return SEL_ERR;
      OFS_EN_SET: return SEL_EN_SET;
      OFS_EN_CLR: return SEL_EN_CLR;
      OFS_DONE:   return SEL_DONE;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dma_irq_flag_bank.sv
`timescale 1ns/1ps
// sticky flags: set by pulse, cleared by write-one, set has priority
module dma_irq_flag_bank #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/dma_irq_en_reg.sv
`timescale 1ns/1ps
module dma_irq_en_reg #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~clr_i;
  end
  assign en_o = en_q;
endmodule

// File: rtl/dma_irq_combine.sv
`timescale 1ns/1ps
module dma_irq_combine #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] err_i,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|err_i) | (|(done_i & en_i));
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_regs.sv
`timescale 1ns/1ps
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned N = NCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  err_evt_i,
  input  logic [N-1:0]  done_evt_i,
  output logic          irq_o
);
  localparam int unsigned PAD = DW - N;

  reg_sel_e     sel;
  logic [N-1:0] wmask;
  logic [N-1:0] err_q, done_q, en_q;
  logic [N-1:0] err_clr, done_clr, en_set, en_clr;

  assign sel   = decode(addr_i);
  assign wmask = wr_en_i ? wdata_i[N-1:0] : '0; // reserved bits dropped here

  assign err_clr  = (sel == SEL_ERR)    ? wmask : '0;
  assign done_clr = (sel == SEL_DONE)   ? wmask : '0;
  assign en_set   = (sel == SEL_EN_SET) ? wmask : '0;
  assign en_clr   = (sel == SEL_EN_CLR) ? wmask : '0;

  dma_irq_flag_bank #(.N(N)) u_err (
    .clk_i, .rst_ni, .set_i(err_evt_i), .clr_i(err_clr), .q_o(err_q)
  );

  dma_irq_flag_bank #(.N(N)) u_done (
    .clk_i, .rst_ni, .set_i(done_evt_i), .clr_i(done_clr), .q_o(done_q)
  );

  dma_irq_en_reg #(.N(N)) u_en (
    .clk_i, .rst_ni, .set_i(en_set), .clr_i(en_clr), .en_o(en_q)
  );

  dma_irq_combine #(.N(N)) u_irq (
    .clk_i, .rst_ni, .err_i(err_q), .done_i(done_q), .en_i(en_q), .irq_o
  );

  logic [N-1:0] rd_val;
  always_comb begin
    unique case (sel)
      SEL_ERR:    rd_val = err_q;
      SEL_EN_SET: rd_val = en_q;
      SEL_DONE:   rd_val = done_q;
      default:    rd_val = '0;
    endcase
  end

  assign rdata_o = rd_en_i ? {{PAD{1'b0}}, rd_val} : '0;
endmodule

// File: rtl/dma_irq_regs_chk.sv
`timescale 1ns/1ps
module dma_irq_regs_chk
  import dma_irq_pkg::*;
#(
  parameter int unsigned N = NCH
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [N-1:0]  err_evt_i,
  input logic [N-1:0]  done_evt_i,
  input logic          irq_o,
  input logic [N-1:0]  err_q,
  input logic [N-1:0]  done_q,
  input logic [N-1:0]  en_q
);
  // R9
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:N] == '0);

  // R4
  err_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_evt_i) |=> ((err_q & $past(err_evt_i)) == $past(err_evt_i)));

  // R3
  err_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_ERR) |=>
      ((err_q & $past(wdata_i[N-1:0] & ~err_evt_i)) == '0));

  // R7
  done_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_evt_i) |=> ((done_q & $past(done_evt_i)) == $past(done_evt_i)));

  // R5
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_EN_SET) |=>
      ((en_q & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_EN_CLR) |=>
      ((en_q & $past(wdata_i[N-1:0])) == '0));

  // R8
  irq_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_q) |=> irq_o);
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.N(N)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rdata_o,
  .err_evt_i, .done_evt_i, .irq_o,
  .err_q(err_q), .done_q(done_q), .en_q(en_q)
);

// File: tb/sim_dma_irq_regs.sv
`timescale 1ns/1ps
module sim_dma_irq_regs;
  localparam int N = 18;
  // op: 0 write, 1 read+compare, 2 error pulse, 3 completion pulse
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'h40, 32'h0,        4'd1},  // R1 flags zero
    '{2'd1, 8'h48, 32'h0,        4'd1},  // R1 enables zero
    '{2'd2, 8'h00, 32'h5,        4'd2},
    '{2'd1, 8'h40, 32'h5,        4'd2},  // R2
    '{2'd0, 8'h40, 32'hFFFC0004, 4'd3},
    '{2'd1, 8'h40, 32'h1,        4'd3},  // R3
    '{2'd0, 8'h48, 32'hFFFFF00F, 4'd5},
    '{2'd1, 8'h48, 32'h3F00F,    4'd9},  // R9 upper bits dropped
    '{2'd0, 8'h48, 32'h0,        4'd5},
    '{2'd1, 8'h48, 32'h3F00F,    4'd5},  // R5 zero write no effect
    '{2'd0, 8'h50, 32'h0000F003, 4'd6},
    '{2'd1, 8'h48, 32'h3000C,    4'd6},  // R6
    '{2'd1, 8'h50, 32'h0,        4'd6},  // R6 write-only
    '{2'd3, 8'h00, 32'h20010,    4'd7},
    '{2'd1, 8'h58, 32'h20010,    4'd7},  // R7
    '{2'd0, 8'h58, 32'h10,       4'd7},
    '{2'd1, 8'h58, 32'h20000,    4'd7},  // R7
    '{2'd1, 8'h60, 32'h0,        4'd9},  // R9 unmapped
    '{2'd0, 8'h40, 32'h1,        4'd3}
  };

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 0, rd_en_i = 0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N-1:0] err_evt_i = '0, done_evt_i = '0;
  logic        irq_o;

  int errors = 0, checks = 0;
  bit done_flag = 0;

  always #4 clk_i = ~clk_i;

  dma_irq_regs u0 (.*);

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic idle();
    wr_en_i = 0; rd_en_i = 0; err_evt_i = '0; done_evt_i = '0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1; cyc(); idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1; #1 d = rdata_o; cyc(); idle();
  endtask

  task automatic do_reset();
    idle(); rst_ni = 0; #20; @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    do_reset();
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: begin
          rd(VEC[i].addr, r);
          check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].data);
        end
        2'd2: begin err_evt_i = VEC[i].data[N-1:0]; cyc(); idle(); end
        default: begin done_evt_i = VEC[i].data[N-1:0]; cyc(); idle(); end
      endcase
    end

    // R8 error on disabled channel, one-cycle latency
    do_reset();
    err_evt_i = 18'h20; cyc(); idle();
    check("R8 irq before stage", {31'b0, irq_o}, 32'h0);
    cyc();
    check("R8 irq error ignores enable", {31'b0, irq_o}, 32'h1);
    wr(8'h40, 32'h20);
    check("R8 irq after clear lag", {31'b0, irq_o}, 32'h1);
    cyc();
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);

    // R8 completion needs enable
    done_evt_i = 18'h8; cyc(); idle(); cyc();
    check("R8 done masked", {31'b0, irq_o}, 32'h0);
    wr(8'h48, 32'h8);
    check("R8 enable lag", {31'b0, irq_o}, 32'h0);
    cyc();
    check("R8 done enabled", {31'b0, irq_o}, 32'h1);
    wr(8'h50, 32'h8); cyc();
    check("R8 enable cleared", {31'b0, irq_o}, 32'h0);

    // R4 error set wins over clear
    addr_i = 8'h40; wdata_i = 32'h80; wr_en_i = 1; err_evt_i = 18'h80; cyc(); idle();
    rd(8'h40, r);
    check("R4 set wins", r, 32'h80);

    // R7 completion set wins over clear
    addr_i = 8'h58; wdata_i = 32'h3FFFF; wr_en_i = 1; done_evt_i = 18'h100; cyc(); idle();
    rd(8'h58, r);
    check("R7 set wins", r, 32'h100);

    // R10 reads have no side effects
    rd(8'h40, r); rd(8'h40, r2);
    check("R10 repeat read", r2, r);
    check("R10 value kept", r2, 32'h80);

    // R9 idle read bus is zero
    #1 check("R9 no read strobe", rdata_o, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule